// File: doc/BRIEF.md
# Automatic Hardware Handshake Controller for a Serial Port

This block runs the two hardware handshake lines of an asynchronous serial port that has a receive FIFO. On the receive side it compares the FIFO fill count with a programmable trigger level. The comparison uses a programmable hysteresis band. The block drives the active-low request-to-send line high to ask the remote end to pause when the FIFO gets too full. It drives the line low again once enough data has been drained. When automatic mode is off, the line follows a software-controlled bit.

On the transmit side the block synchronises the active-low clear-to-send input and produces a transmit-permit level for the local serializer. The serializer may start a new character, or keep shifting one, only while permit is high. When clear-to-send goes inactive, the block does not lower permit in the middle of a character. It keeps permit high until the serializer reports that the character has finished, and then holds it low. Each direction also produces a one-cycle event pulse: the clear-to-send input going high, and the block itself raising request-to-send.

Top module: `uart_hw_flowctl`

## Requirements
- R1: During and directly after reset, `rts_n` is 1 and `tx_permit` is 1, and both `rts_evt` and `cts_evt` are 0.
- R2: With `auto_rts_en`=1, a clock edge at which `rx_level` is greater than `rts_trig + H` sets `rts_n` to 1. H is the hysteresis amount. The upper threshold is computed without wrap-around, so a sum beyond the level range is never exceeded.
- R3: With `auto_rts_en`=1, a clock edge at which `rx_level` is less than `rts_trig - H` (floored at 0) sets `rts_n` to 0. A level between the two thresholds, the thresholds included, keeps `rts_n` unchanged.
- R4: H equals 4 × `hyst_sel` characters for codes 0 to 9. Codes 10 to 15 give 36. With code 0 both thresholds equal `rts_trig`.
- R5: With `auto_rts_en`=0, `rts_n` takes the value NOT `sw_rts` at every clock edge, whatever `rx_level` is.
- R6: With `auto_cts_en`=1 and no character in flight, `cts_n` going to 1 makes `tx_permit` fall on the third rising edge after the change. `cts_n` returning to 0 makes it rise on the third edge.
- R7: A character is in flight from a `tx_start` pulse until a `tx_done` pulse. While it is in flight, `tx_permit` stays 1 even with `cts_n`=1. It falls on the edge that samples `tx_done`.
- R8: With `auto_cts_en`=0, `tx_permit` is 1 regardless of `cts_n`, and `cts_evt` stays 0.
- R9: With `auto_cts_en`=1, a low-to-high change of `cts_n` gives a `cts_evt` pulse exactly one clock long. The pulse is high in the cycle after the second rising edge following the change.
- R10: `rts_evt` is a one-cycle pulse in the first cycle that `rts_n` is 1 after being 0, and only when automatic mode caused the rise. A rise caused by `sw_rts` gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Current receive FIFO fill count |
| rts_trig | input | LVL_W | Flow-control trigger level |
| hyst_sel | input | HSEL_W | Hysteresis code |
| auto_rts_en | input | 1 | Enable automatic request-to-send |
| auto_cts_en | input | 1 | Enable automatic clear-to-send gating |
| sw_rts | input | 1 | Software request bit (1 asserts, drives `rts_n` low) |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| tx_start | input | 1 | Serializer begins a character (pulse) |
| tx_done | input | 1 | Serializer finished a character (pulse) |
| rts_n | output | 1 | Active-low request-to-send |
| tx_permit | output | 1 | Serializer may send while high |
| rts_evt | output | 1 | Pulse: automatic mode raised `rts_n` |
| cts_evt | output | 1 | Pulse: `cts_n` went high under automatic mode |

## Verification
Each result has a fixed delay after its stimulus:
- `rts_n` and `rts_evt` change one rising edge after the level or enable input that causes them.
- `cts_evt` is visible after the second edge following a `cts_n` change.
- `tx_permit` reacts on the third edge, or on the edge that samples `tx_done` while a character is in flight.

Directed checks drive inputs just after a falling edge and count whole cycles before sampling at the next falling edge. A behavioural model, built on a history queue of sampled clear-to-send values, is compared with every output two nanoseconds after each rising edge, across directed and randomised traffic.

// File: rtl/uart_fc_pkg.sv
// Package: shared types and helpers for the hardware handshake controller.
// Assumes: hysteresis is a whole number of characters, a multiple of a step.
package uart_fc_pkg;

    // Request line meaning when the block drives it.
    typedef enum logic {
        RTS_GO   = 1'b0,
        RTS_STOP = 1'b1
    } rts_line_e;

    // Hysteresis amount in characters for a select code, saturating at max_code.
    function automatic int unsigned hyst_chars(input int unsigned code,
                                               input int unsigned step,
                                               input int unsigned max_code);
        return ((code > max_code) ? max_code : code) * step;
    endfunction

endpackage

// File: rtl/fc_threshold.sv
// Module: fc_threshold
// Derives the upper and lower fill thresholds from the trigger and hysteresis code.
// Assumes: results are one bit wider than the level, so the upper sum never wraps;
// the lower threshold floors at zero.
module fc_threshold
    import uart_fc_pkg::*;
#(
    parameter int unsigned LVL_W     = 7,
    parameter int unsigned HSEL_W    = 4,
    parameter int unsigned HSTEP     = 4,
    parameter int unsigned HMAX_CODE = 9
) (
    input  logic [LVL_W-1:0]  trig,
    input  logic [HSEL_W-1:0] hsel,
    output logic [LVL_W:0]    thr_hi,
    output logic [LVL_W:0]    thr_lo
);
    localparam int unsigned EXT_W = LVL_W + 1;

    logic [EXT_W-1:0] band;
    logic [EXT_W-1:0] trig_ext;

    // Purpose: widen the trigger and turn the code into a character count.
    always_comb begin
        trig_ext = {1'b0, trig};
        band     = EXT_W'(hyst_chars(32'(hsel), HSTEP, HMAX_CODE));
    end

    // Purpose: place the band symmetrically around the trigger.
    always_comb begin
        thr_hi = trig_ext + band;
        thr_lo = (trig_ext >= band) ? (trig_ext - band) : '0;
    end
endmodule

// File: rtl/fc_rts_ctrl.sv
// Module: fc_rts_ctrl
// Drives the active-low request line from the fill level and the two thresholds,
// or from the software bit when automatic mode is off, and flags automatic rises.
// Assumes: thr_lo <= thr_hi; the level is sampled every clock.
module fc_rts_ctrl
    import uart_fc_pkg::*;
#(
    parameter int unsigned LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W:0]   thr_hi,
    input  logic [LVL_W:0]   thr_lo,
    input  logic             auto_en,
    input  logic             sw_rts,
    output logic             rts_n,
    output logic             rise_evt
);
    rts_line_e line_q, line_d;
    logic [LVL_W:0] level_ext;

    // Purpose: pick the next line state (software, stop, go or hold).
    always_comb begin
        level_ext = {1'b0, level};
        if (!auto_en)
            line_d = sw_rts ? RTS_GO : RTS_STOP;
        else if (level_ext > thr_hi)
            line_d = RTS_STOP;
        else if (level_ext < thr_lo)
            line_d = RTS_GO;
        else
            line_d = line_q;
    end

    // Purpose: register the line and the automatic-rise pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= RTS_STOP;
            rise_evt <= 1'b0;
        end else begin
            line_q   <= line_d;
            rise_evt <= auto_en && (line_d == RTS_STOP) && (line_q == RTS_GO);
        end
    end

    assign rts_n = (line_q == RTS_STOP);
endmodule

// File: rtl/fc_cts_sync.sv
// Module: fc_cts_sync
// Brings the asynchronous clear-to-send input into the clock domain and finds
// its synchronised low-to-high change.
// Assumes: STAGES >= 2; the reset value treats the line as active (low).
module fc_cts_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    output logic cts_stop,
    output logic cts_rise
);
    logic [STAGES:0] chain;

    // Purpose: shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-1:0], cts_n};
    end

    assign cts_stop = chain[STAGES-1];
    assign cts_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fc_tx_gate.sv
// Module: fc_tx_gate
// Produces the transmit-permit level. Permit drops only at a character boundary:
// while a character is in flight it stays high even if the far end says stop.
// Assumes: the serializer pulses start and done once per character.
module fc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_stop,
    input  logic tx_start,
    input  logic tx_done,
    output logic tx_permit
);
    logic busy_q, busy_d, permit_d;

    // Purpose: track the in-flight character and decide the next permit.
    always_comb begin
        busy_d   = tx_start | (busy_q & ~tx_done);
        permit_d = ~auto_en | ~cts_stop | busy_d;
    end

    // Purpose: hold in-flight state and the registered permit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            tx_permit <= 1'b1;
        end else begin
            busy_q    <= busy_d;
            tx_permit <= permit_d;
        end
    end
endmodule

// File: rtl/uart_hw_flowctl.sv
// Module: uart_hw_flowctl (top)
// Automatic request-to-send / clear-to-send handshake for a serial port.
// Assumes: rx_level is already in this clock domain; cts_n may be asynchronous.
module uart_hw_flowctl #(
    parameter int unsigned LVL_W       = 7,
    parameter int unsigned HSEL_W      = 4,
    parameter int unsigned HSTEP       = 4,
    parameter int unsigned HMAX_CODE   = 9,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  rts_trig,
    input  logic [HSEL_W-1:0] hyst_sel,
    input  logic              auto_rts_en,
    input  logic              auto_cts_en,
    input  logic              sw_rts,
    input  logic              cts_n,
    input  logic              tx_start,
    input  logic              tx_done,
    output logic              rts_n,
    output logic              tx_permit,
    output logic              rts_evt,
    output logic              cts_evt
);
    logic [LVL_W:0] thr_hi, thr_lo;
    logic           cts_stop, cts_rise;

    fc_threshold #(
        .LVL_W(LVL_W), .HSEL_W(HSEL_W), .HSTEP(HSTEP), .HMAX_CODE(HMAX_CODE)
    ) u_thr (
        .trig(rts_trig), .hsel(hyst_sel), .thr_hi(thr_hi), .thr_lo(thr_lo)
    );

    fc_rts_ctrl #(.LVL_W(LVL_W)) u_rts (
        .clk(clk), .rst_n(rst_n), .level(rx_level), .thr_hi(thr_hi),
        .thr_lo(thr_lo), .auto_en(auto_rts_en), .sw_rts(sw_rts),
        .rts_n(rts_n), .rise_evt(rts_evt)
    );

    fc_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n),
        .cts_stop(cts_stop), .cts_rise(cts_rise)
    );

    fc_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_stop(cts_stop),
        .tx_start(tx_start), .tx_done(tx_done), .tx_permit(tx_permit)
    );

    // Purpose: report the synchronised clear-to-send rise only in automatic mode.
    assign cts_evt = auto_cts_en & cts_rise;
endmodule

// File: rtl/uart_hw_flowctl_chk.sv
// Module: uart_hw_flowctl_chk
// Property checker bound to the top; sees only the top's ports.
// Assumes: same parameters as the bound instance.
module uart_hw_flowctl_chk #(
    parameter int unsigned LVL_W     = 7,
    parameter int unsigned HSEL_W    = 4,
    parameter int unsigned HSTEP     = 4,
    parameter int unsigned HMAX_CODE = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  rts_trig,
    input logic [HSEL_W-1:0] hyst_sel,
    input logic              auto_rts_en,
    input logic              auto_cts_en,
    input logic              sw_rts,
    input logic              tx_start,
    input logic              rts_n,
    input logic              tx_permit,
    input logic              rts_evt,
    input logic              cts_evt
);
    int unsigned band, up, dn, lv;

    // Purpose: independent view of the two thresholds in plain integers.
    always_comb begin
        band = (32'(hyst_sel) >= HMAX_CODE) ? HMAX_CODE * HSTEP : 32'(hyst_sel) * HSTEP;
        up   = 32'(rts_trig) + band;
        dn   = (32'(rts_trig) > band) ? 32'(rts_trig) - band : 0;
        lv   = 32'(rx_level);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rts_n && tx_permit && !rts_evt && !cts_evt));

    assert_rts_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && lv > up) |=> rts_n);

    assert_rts_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && lv < dn) |=> !rts_n);

    assert_rts_soft_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(sw_rts)));

    assert_inflight_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && tx_start) |=> tx_permit);

    assert_cts_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_cts_en |=> tx_permit);

    assert_cts_evt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cts_evt |=> !cts_evt);

    assert_rts_evt_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rts_evt |-> ($rose(rts_n) && $past(auto_rts_en)));
endmodule

bind uart_hw_flowctl uart_hw_flowctl_chk #(
    .LVL_W(LVL_W), .HSEL_W(HSEL_W), .HSTEP(HSTEP), .HMAX_CODE(HMAX_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rts_trig(rts_trig),
    .hyst_sel(hyst_sel), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .sw_rts(sw_rts), .tx_start(tx_start), .rts_n(rts_n), .tx_permit(tx_permit),
    .rts_evt(rts_evt), .cts_evt(cts_evt)
);

// File: tb/uart_hw_flowctl_tb.sv
// Bench: directed checks plus a behavioural model compared after every edge.
module uart_hw_flowctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] rx_level = '0, rts_trig = '0;
    logic [3:0] hyst_sel = '0;
    logic       auto_rts_en = 0, auto_cts_en = 0, sw_rts = 0;
    logic       cts_n = 0, tx_start = 0, tx_done = 0;
    logic       rts_n, tx_permit, rts_evt, cts_evt;

    int total = 0, bad = 0, cyc = 0;
    bit done = 0, cmp_on = 0;

    always #5 clk = ~clk;

    uart_hw_flowctl u_dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rts_trig(rts_trig),
        .hyst_sel(hyst_sel), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_rts(sw_rts), .cts_n(cts_n), .tx_start(tx_start), .tx_done(tx_done),
        .rts_n(rts_n), .tx_permit(tx_permit), .rts_evt(rts_evt), .cts_evt(cts_evt)
    );

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference model.
    int m_rts = 1, m_rtsevt = 0, m_perm = 1, m_busy = 0;
    int hist[$] = '{0, 0, 0};

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_rts = 1; m_rtsevt = 0; m_perm = 1; m_busy = 0;
            hist = '{0, 0, 0};
        end else begin
            int h, hi, lo, nr;
            h  = (hyst_sel > 9 ? 9 : int'(hyst_sel)) * 4;
            hi = int'(rts_trig) + h;
            lo = (int'(rts_trig) - h < 0) ? 0 : int'(rts_trig) - h;
            if (!auto_rts_en)             nr = sw_rts ? 0 : 1;
            else if (int'(rx_level) > hi) nr = 1;
            else if (int'(rx_level) < lo) nr = 0;
            else                          nr = m_rts;
            m_rtsevt = (auto_rts_en && nr == 1 && m_rts == 0) ? 1 : 0;
            m_rts = nr;
            if (tx_start)     m_busy = 1;
            else if (tx_done) m_busy = 0;
            m_perm = (!auto_cts_en || hist[1] == 0 || m_busy == 1) ? 1 : 0;
            hist.push_front(int'(cts_n));
            void'(hist.pop_back());
        end
    end

    // Compare after every rising edge, well before the drivers move.
    always begin
        @(posedge clk);
        #2;
        if (cmp_on && rst_n && !done) begin
            chk("R2/R3/R4/R5 model rts_n", int'(rts_n), m_rts);
            chk("R10 model rts_evt", int'(rts_evt), m_rtsevt);
            chk("R6/R7/R8 model tx_permit", int'(tx_permit), m_perm);
            chk("R9 model cts_evt", int'(cts_evt),
                (auto_cts_en && hist[1] == 1 && hist[2] == 0) ? 1 : 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 50000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 50000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        // r1_ reset state
        chk("R1 reset rts_n", int'(rts_n), 1);
        chk("R1 reset tx_permit", int'(tx_permit), 1);
        chk("R1 reset rts_evt", int'(rts_evt), 0);
        chk("R1 reset cts_evt", int'(cts_evt), 0);
        rst_n = 1;
        step(1);
        chk("R1 after release rts_n", int'(rts_n), 1);
        cmp_on = 1;

        // Code 0: thresholds both at 32.
        auto_rts_en = 1; rts_trig = 32; hyst_sel = 0; rx_level = 10;
        step(1); chk("R3 low level asserts request", int'(rts_n), 0);
        rx_level = 32; step(1); chk("R4 code0 equal level holds", int'(rts_n), 0);
        rx_level = 33; step(1); chk("R2 above trigger stops", int'(rts_n), 1);
        chk("R10 auto rise pulse", int'(rts_evt), 1);
        step(1); chk("R10 pulse one cycle", int'(rts_evt), 0);
        rx_level = 32; step(1); chk("R4 code0 hold high", int'(rts_n), 1);
        rx_level = 31; step(1); chk("R3 below trigger resumes", int'(rts_n), 0);

        // Code 2: band of 8, thresholds 40 / 24.
        hyst_sel = 2;
        rx_level = 40; step(1); chk("R4 at upper threshold holds", int'(rts_n), 0);
        rx_level = 41; step(1); chk("R2 above upper threshold", int'(rts_n), 1);
        rx_level = 24; step(1); chk("R3 at lower threshold holds", int'(rts_n), 1);
        rx_level = 23; step(1); chk("R3 below lower threshold", int'(rts_n), 0);

        // Code 15 saturates at 36: thresholds 76 / 4.
        hyst_sel = 15; rts_trig = 40;
        rx_level = 76; step(1); chk("R4 saturated upper holds", int'(rts_n), 0);
        rx_level = 77; step(1); chk("R4 saturated upper stops", int'(rts_n), 1);
        rx_level = 4;  step(1); chk("R4 saturated lower holds", int'(rts_n), 1);
        rx_level = 3;  step(1); chk("R4 saturated lower resumes", int'(rts_n), 0);

        // Lower threshold floored at 0: never resumes.
        hyst_sel = 9; rts_trig = 10;
        rx_level = 47; step(1); chk("R2 trig10 code9 stops", int'(rts_n), 1);
        rx_level = 0;  step(2); chk("R3 floored threshold holds at empty", int'(rts_n), 1);

        // Software mode.
        auto_rts_en = 0; sw_rts = 1; rx_level = 100;
        step(1); chk("R5 software assert ignores level", int'(rts_n), 0);
        sw_rts = 0; step(1); chk("R5 software release", int'(rts_n), 1);
        chk("R10 no pulse on software rise", int'(rts_evt), 0);

        // Clear-to-send gating, nothing in flight.
        auto_cts_en = 1; cts_n = 1;
        step(1); chk("R6 permit after one edge", int'(tx_permit), 1);
        chk("R9 no event after one edge", int'(cts_evt), 0);
        step(1); chk("R9 event after two edges", int'(cts_evt), 1);
        chk("R6 permit after two edges", int'(tx_permit), 1);
        step(1); chk("R6 permit falls on third edge", int'(tx_permit), 0);
        chk("R9 event one cycle", int'(cts_evt), 0);
        cts_n = 0;
        step(2); chk("R6 permit still low", int'(tx_permit), 0);
        step(1); chk("R6 permit returns on third edge", int'(tx_permit), 1);

        // Character in flight.
        tx_start = 1; step(1); tx_start = 0;
        cts_n = 1; step(6); chk("R7 permit held mid character", int'(tx_permit), 1);
        tx_done = 1; step(1); tx_done = 0;
        chk("R7 permit falls at boundary", int'(tx_permit), 0);
        cts_n = 0; step(3); chk("R7 permit back after resume", int'(tx_permit), 1);

        // Automatic clear-to-send off.
        auto_cts_en = 0; cts_n = 1;
        step(2); chk("R8 no event when disabled", int'(cts_evt), 0);
        step(2); chk("R8 permit ignores line", int'(tx_permit), 1);
        cts_n = 0; step(3);

        // Randomised traffic against the model.
        for (int i = 0; i < 3000; i++) begin
            rx_level = 7'($urandom_range(0, 120));
            if ($urandom_range(0, 15) == 0) rts_trig = 7'($urandom_range(0, 63));
            if ($urandom_range(0, 15) == 0) hyst_sel = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 63) == 0) auto_rts_en = ~auto_rts_en;
            if ($urandom_range(0, 63) == 0) auto_cts_en = ~auto_cts_en;
            if ($urandom_range(0, 7) == 0) sw_rts = ~sw_rts;
            if ($urandom_range(0, 9) == 0) cts_n = ~cts_n;
            tx_start = ($urandom_range(0, 11) == 0);
            tx_done  = ($urandom_range(0, 9) == 0);
            step(1);
        end
        tx_start = 0; tx_done = 0;
        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule